// File: doc/BRIEF.md
# Quota-Aware Replacement Way Chooser

When a shared set-associative cache misses, one way of the indexed set has to be given up. This block makes that choice so that each core stays within the number of ways it has been granted. Every way reports whether it is valid, which core installed it, and where it sits in the recency order. The requesting core's id and its way quota come in with the miss. The block returns the index of the way to replace.

It works out how many valid ways the requester already holds in the set. A requester below its quota takes a way from another core. A requester at or above its quota replaces one of its own lines. Within the chosen group, the least recently used line is the one given up. Empty ways are always filled first. If the chosen group has no member, the least recently used line of the whole set is used instead. The block is purely combinational: the answer is ready in the same cycle as the miss. Keeping the recency order up to date and moving data are handled elsewhere.

Top module: `vsel_victim_top`

## Requirements
- R1: `victim_way` is a combinational function of the inputs. It settles in the same cycle as the request and always names a way below NUM_WAYS.
- R2: The requester's occupancy counts only those ways whose valid bit is 1 and whose owner field (CORE_W bits at offset i*CORE_W of `way_owner`) equals `req_core`.
- R3: If any way has its valid bit at 0, the victim is the lowest-indexed such way, whatever the owners, ranks and quota.
- R4: If all ways are valid, the occupancy is below `req_quota`, and at least one way belongs to another core, then the victim is the way owned by another core that has the largest rank.
- R5: If all ways are valid, the occupancy is at least `req_quota`, and the requester owns at least one way, then the victim is the requester's way that has the largest rank.
- R6: If all ways are valid and the group chosen by R4 or R5 is empty, the victim is the way with the largest rank in the whole set. This applies when the requester is under quota but owns every way, and when it is at quota with no ways owned (quota 0).
- R7: Ranks are RANK_W-bit fields at offset i*RANK_W of `way_rank`. Rank 0 means most recently used and NUM_WAYS-1 means least recently used. When several candidates share the largest rank, the lowest index among them wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_core | input | CORE_W | Id of the core that missed |
| req_quota | input | CNT_W | Number of ways granted to that core, 0 to NUM_WAYS |
| way_valid | input | NUM_WAYS | Valid bit of each way |
| way_owner | input | NUM_WAYS*CORE_W | Owner core id of each way, packed |
| way_rank | input | NUM_WAYS*RANK_W | Recency rank of each way, packed |
| victim_way | output | IDX_W | Index of the way to replace |

## Verification
The hardest cases to reach are the two fallback conditions of R6. Reaching either one needs every way valid, together with an owner pattern that empties the group the quota comparison has just selected. These cases also have to be told apart from the ordinary group picks, which can return the same index by coincidence. The bench therefore sweeps every valid mask, every owner mask, both requesters and every quota from 0 up to the way count. It crosses these with nine rank layouts: rotations, reversed rotations, and an all-equal layout that exercises the tie rule. This way each fallback is hit many times, with the global least recently used way in different positions.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    SRC_EMPTY    = 2'd0,
    SRC_GROUP    = 2'd1,
    SRC_FALLBACK = 2'd2
  } vsel_src_e;
endpackage

// File: rtl/vsel_occupancy.sv
module vsel_occupancy #(
  parameter int NUM_WAYS  = 8,
  parameter int NUM_CORES = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int CNT_W    = $clog2(NUM_WAYS + 1)
) (
  input  logic [CORE_W-1:0]          req_core,
  input  logic [NUM_WAYS-1:0]        way_valid,
  input  logic [NUM_WAYS*CORE_W-1:0] way_owner,
  output logic [NUM_WAYS-1:0]        own_mask,
  output logic [CNT_W-1:0]           own_count
);
  always_comb begin
    own_count = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      own_mask[i] = way_valid[i] && (way_owner[i*CORE_W +: CORE_W] == req_core);
      own_count   = own_count + {{(CNT_W-1){1'b0}}, own_mask[i]};
    end
  end
endmodule

// File: rtl/vsel_first_clear.sv
module vsel_first_clear #(
  parameter int NUM_WAYS = 8,
  localparam int IDX_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0] way_valid,
  output logic [IDX_W-1:0]    hole_idx,
  output logic                hole_any
);
  always_comb begin
    hole_idx = '0;
    hole_any = 1'b0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) begin
        hole_idx = IDX_W'(i);
        hole_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vsel_lru_pick.sv
module vsel_lru_pick #(
  parameter int NUM_WAYS = 8,
  localparam int IDX_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int RANK_W  = IDX_W
) (
  input  logic [NUM_WAYS-1:0]        cand_mask,
  input  logic [NUM_WAYS*RANK_W-1:0] way_rank,
  output logic [IDX_W-1:0]           pick_idx,
  output logic                       pick_any
);
  logic [RANK_W-1:0] best_rank;

  always_comb begin
    pick_idx  = '0;
    pick_any  = 1'b0;
    best_rank = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (cand_mask[i] && (!pick_any || (way_rank[i*RANK_W +: RANK_W] > best_rank))) begin
        pick_idx  = IDX_W'(i);
        pick_any  = 1'b1;
        best_rank = way_rank[i*RANK_W +: RANK_W];
      end
    end
  end
endmodule

// File: rtl/vsel_victim_top.sv
module vsel_victim_top #(
  parameter int NUM_WAYS  = 8,
  parameter int NUM_CORES = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int RANK_W   = IDX_W,
  localparam int CNT_W    = $clog2(NUM_WAYS + 1)
) (
  input  logic [CORE_W-1:0]          req_core,
  input  logic [CNT_W-1:0]           req_quota,
  input  logic [NUM_WAYS-1:0]        way_valid,
  input  logic [NUM_WAYS*CORE_W-1:0] way_owner,
  input  logic [NUM_WAYS*RANK_W-1:0] way_rank,
  output logic [IDX_W-1:0]           victim_way
);
  import vsel_pkg::*;

  logic [NUM_WAYS-1:0]       own_mask;
  logic [CNT_W-1:0]          own_count;
  logic                      under_quota;
  logic [IDX_W-1:0]          hole_idx;
  logic                      hole_any;
  logic [1:0][NUM_WAYS-1:0]  pick_mask;
  logic [1:0][IDX_W-1:0]     pick_idx;
  logic [1:0]                pick_any;
  vsel_src_e                 victim_src;

  vsel_occupancy #(.NUM_WAYS(NUM_WAYS), .NUM_CORES(NUM_CORES)) u_occ (
    .req_core (req_core),
    .way_valid(way_valid),
    .way_owner(way_owner),
    .own_mask (own_mask),
    .own_count(own_count)
  );

  vsel_first_clear #(.NUM_WAYS(NUM_WAYS)) u_hole (
    .way_valid(way_valid),
    .hole_idx (hole_idx),
    .hole_any (hole_any)
  );

  assign under_quota  = own_count < req_quota;
  // slot 0: quota-selected group, slot 1: whole set
  assign pick_mask[0] = under_quota ? (way_valid & ~own_mask) : own_mask;
  assign pick_mask[1] = way_valid;

  for (genvar g = 0; g < 2; g++) begin : g_pick
    vsel_lru_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
      .cand_mask(pick_mask[g]),
      .way_rank (way_rank),
      .pick_idx (pick_idx[g]),
      .pick_any (pick_any[g])
    );
  end

  always_comb begin
    if (hole_any)         victim_src = SRC_EMPTY;
    else if (pick_any[0]) victim_src = SRC_GROUP;
    else                  victim_src = SRC_FALLBACK;
  end

  always_comb begin
    unique case (victim_src)
      SRC_EMPTY:    victim_way = hole_idx;
      SRC_GROUP:    victim_way = pick_idx[0];
      default:      victim_way = pick_idx[1];
    endcase
  end
endmodule

// File: rtl/vsel_victim_check.sv
module vsel_victim_check #(
  parameter int NUM_WAYS  = 8,
  parameter int NUM_CORES = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int RANK_W   = IDX_W,
  localparam int CNT_W    = $clog2(NUM_WAYS + 1)
) (
  input logic [CORE_W-1:0]          req_core,
  input logic [CNT_W-1:0]           req_quota,
  input logic [NUM_WAYS-1:0]        way_valid,
  input logic [NUM_WAYS*CORE_W-1:0] way_owner,
  input logic [NUM_WAYS*RANK_W-1:0] way_rank,
  input logic [IDX_W-1:0]           victim_way
);
  int   held;
  logic mine_seen, other_seen, all_full, below, vic_mine, rank_ok;

  always_comb begin
    held = 0;
    mine_seen = 1'b0;
    other_seen = 1'b0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      if (way_owner[k*CORE_W +: CORE_W] == req_core) begin
        held = held + (way_valid[k] ? 1 : 0);
        mine_seen = 1'b1;
      end else begin
        other_seen = 1'b1;
      end
    end
    all_full = &way_valid;
    below    = held < int'(req_quota);
    vic_mine = way_owner[int'(victim_way)*CORE_W +: CORE_W] == req_core;
    rank_ok  = 1'b1;
    for (int k = 0; k < NUM_WAYS; k++) begin
      if (way_rank[k*RANK_W +: RANK_W] > way_rank[int'(victim_way)*RANK_W +: RANK_W])
        rank_ok = 1'b0;
    end

    AST_VICTIM_IN_RANGE: assert (int'(victim_way) < NUM_WAYS); // R1
    if (!all_full) begin
      AST_EMPTY_FIRST: assert (!way_valid[victim_way]); // R3
      for (int k = 0; k < NUM_WAYS; k++) begin
        if (k < int'(victim_way)) begin
          AST_LOWEST_EMPTY: assert (way_valid[k]); // R3
        end
      end
    end else begin
      if (below && other_seen) begin
        AST_UNDER_TAKES_OTHER: assert (!vic_mine); // R4
      end
      if (!below && mine_seen) begin
        AST_OVER_TAKES_OWN: assert (vic_mine); // R5
      end
      if ((below && !other_seen) || (!below && !mine_seen)) begin
        AST_FALLBACK_SET_LRU: assert (rank_ok); // R6
      end
    end
  end
endmodule

bind vsel_victim_top vsel_victim_check #(.NUM_WAYS(NUM_WAYS), .NUM_CORES(NUM_CORES)) u_vsel_chk (
  .req_core  (req_core),
  .req_quota (req_quota),
  .way_valid (way_valid),
  .way_owner (way_owner),
  .way_rank  (way_rank),
  .victim_way(victim_way)
);

// File: tb/vsel_victim_top_test.sv
`timescale 1ns/1ps
module vsel_victim_top_test;
  localparam int W = 4;
  localparam int C = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_core;
  logic [2:0] req_quota;
  logic [3:0] way_valid;
  logic [3:0] way_owner;
  logic [7:0] way_rank;
  logic [1:0] victim_way;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  vsel_victim_top #(.NUM_WAYS(W), .NUM_CORES(C)) uut (
    .req_core  (req_core),
    .req_quota (req_quota),
    .way_valid (way_valid),
    .way_owner (way_owner),
    .way_rank  (way_rank),
    .victim_way(victim_way)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: victim=%0d expected=%0d (valid=%b owner=%b core=%0d quota=%0d rank=%h)",
               tag, got, exp, way_valid, way_owner, req_core, req_quota, way_rank);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic int rank_of(input int mode, input int w);
    if (mode < 4)      return (w + mode) % 4;
    else if (mode < 8) return (3 - w + mode) % 4;
    else               return 0;
  endfunction

  initial begin
    req_core = 0; req_quota = 0; way_valid = 0; way_owner = 0; way_rank = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 idle all-empty", victim_way, 0);

    for (int vm = 0; vm < 16; vm++)
      for (int om = 0; om < 16; om++)
        for (int rc = 0; rc < 2; rc++)
          for (int q = 0; q <= 4; q++)
            for (int md = 0; md < 9; md++) begin
              int held, exp, best, cnt_group;
              bit below;
              string tag;
              way_valid = 4'(vm);
              way_owner = 4'(om);
              req_core  = rc[0];
              req_quota = 3'(q);
              for (int w = 0; w < 4; w++) way_rank[w*2 +: 2] = 2'(rank_of(md, w));
              #1;
              held = 0;
              for (int w = 0; w < 4; w++)
                if (vm[w] && (om[w] == rc[0])) held++;
              below = held < q;
              exp = -1;
              for (int w = 3; w >= 0; w--) if (!vm[w]) exp = w;
              if (exp >= 0) tag = "R3";
              else begin
                best = -1; cnt_group = 0;
                for (int w = 0; w < 4; w++)
                  if ((om[w] != rc[0]) == below) begin
                    cnt_group++;
                    if (rank_of(md, w) > best) begin best = rank_of(md, w); exp = w; end
                  end
                if (cnt_group > 0) tag = below ? "R4 (R2)" : "R5 (R2)";
                else begin
                  tag = "R6";
                  best = -1;
                  for (int w = 0; w < 4; w++)
                    if (rank_of(md, w) > best) begin best = rank_of(md, w); exp = w; end
                end
                if (md == 8) tag = {tag, " R7 tie"};
              end
              check(tag, victim_way, exp);
              #1;
            end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got=hang expected=done");
      summary();
      $finish;
    end
  end
endmodule